// File: doc/BRIEF.md
# Host-Clocked Serial Read Port with Data-Ready Flag

This block is the read side of a converter's serial port when the host supplies the shift clock. The host lowers a frame strobe. The block then shifts a word out on a serial data line, most significant bit first, and changes one bit for each falling edge of the host clock. An address select line picks the word to be shifted. With the select high, the port returns the conversion output word, or the calibration word when a calibration select is also high. With the select low, it returns the control word. The converter core supplies these values on parallel inputs, and it pulses a load strobe whenever a fresh output word is ready.

An active-low data-ready flag tells the host that an unread output word is waiting. The flag drops when a word is loaded. It rises only after the last bit of that word has been shifted out. The host may raise the frame strobe in the middle of a word. This turns the data driver off but keeps the bit position, and the transfer continues when the strobe falls again. The host clock and the frame strobe are sampled in the `clk` domain, and their edges are detected there. The output word length `OUT_W` is fixed at elaboration to either 16 or 24 bits.

Top module: `hcrp_top`

## Requirements
- R1: One `clk` cycle after a `load_new` pulse that is accepted, `rdy_n` is 0 and the output register holds `new_word`.
- R2: During an output-word read, the `OUT_W`-th host-clock falling edge with the frame low sets `rdy_n` to 1. In the same cycle it drops `sdo_oe`.
- R3: While an output-word read is in progress, a `load_new` pulse has no effect. `rdy_n` is unchanged, the output register is unchanged, and the word is lost.
- R4: With `addr_sel`=1 and `cal_sel`=0, a falling frame strobe while `rdy_n`=1 starts no transfer, and `sdo_oe` stays 0.
- R5: If the output word is not read, further loads replace it. A later read returns the most recent word.
- R6: With `addr_sel`=0, a falling frame strobe always starts a 24-bit read of `ctrl_word`, whatever the state of `rdy_n`. `rdy_n` is not changed by that read.
- R7: With `addr_sel`=1 and `cal_sel`=1, a falling frame strobe always starts a 24-bit read of `cal_word`. `rdy_n` is not changed by that read.
- R8: One `clk` cycle after the frame falls, `sdo_oe`=1 and `sdo` carries the MSB. Each host-clock falling edge with the frame low moves `sdo` to the next lower bit.
- R9: A high frame strobe during a word forces `sdo_oe` to 0 and ignores host-clock edges. When the frame is lowered again, the same bit is presented and shifting continues from there. A second falling frame strobe during a word does not restart it.
- R10: After reset, `rdy_n`=1 and `sdo_oe`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; sampling clock for host inputs |
| rst_n | input | 1 | Active-low asynchronous reset |
| hclk | input | 1 | Host serial clock level |
| frame_n | input | 1 | Active-low read frame strobe |
| addr_sel | input | 1 | 1: output/calibration word, 0: control word |
| cal_sel | input | 1 | With addr_sel=1, 1 selects calibration word |
| load_new | input | 1 | One-cycle strobe: new output word available |
| new_word | input | OUT_W | New conversion output word |
| ctrl_word | input | 24 | Control register contents |
| cal_word | input | 24 | Calibration register contents |
| rdy_n | output | 1 | Active-low data-ready flag |
| sdo | output | 1 | Serial data out (0 when not enabled) |
| sdo_oe | output | 1 | Output enable for the serial data driver |

## Verification
A fault in the bit counter shows at the ports within a single word. `sdo_oe` drops one host-clock edge early or late, or `rdy_n` rises at the wrong edge. A fault in the load-blocking logic leaves `rdy_n` low after an output read that had a word dropped. It then lets the next frame stream a word that should have been refused, which is visible on the very next frame. A shift register that keeps a wrong word, or that loses its position across a pause, gives a wrong `sdo` bit at the first sample after the fault.

// File: rtl/hcrp_pkg.sv
package hcrp_pkg;
    localparam int REG_W = 24;
    localparam int CNT_W = $clog2(REG_W + 1);

    typedef enum logic [1:0] {
        SRC_OUT  = 2'd0,
        SRC_CTRL = 2'd1,
        SRC_CAL  = 2'd2
    } src_e;
endpackage

// File: rtl/hcrp_edge.sv
module hcrp_edge #(
    parameter bit IDLE = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl,
    output logic rise,
    output logic fall
);
    logic prev_d, prev_q;

    always_comb begin
        prev_d = lvl;
        rise   = lvl & ~prev_q;
        fall   = ~lvl & prev_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= IDLE;
        else        prev_q <= prev_d;
    end
endmodule

// File: rtl/hcrp_outreg.sv
module hcrp_outreg #(
    parameter int OUT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_new,
    input  logic [OUT_W-1:0] new_word,
    input  logic             block_load,
    input  logic             out_done,
    output logic [OUT_W-1:0] out_word,
    output logic             rdy_n
);
    typedef struct packed {
        logic [OUT_W-1:0] word;
        logic             rdy_n;
    } oreg_t;

    oreg_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (out_done)
            st_d.rdy_n = 1'b1;
        if (load_new && !block_load) begin
            st_d.word  = new_word;
            st_d.rdy_n = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{word: '0, rdy_n: 1'b1};
        else        st_q <= st_d;
    end

    assign out_word = st_q.word;
    assign rdy_n    = st_q.rdy_n;

    // R1
    rdy_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(st_q.rdy_n) |-> $past(load_new));
    // R3
    drop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (load_new && block_load) |=> $stable(st_q.word));
endmodule

// File: rtl/hcrp_shifter.sv
module hcrp_shifter
    import hcrp_pkg::*;
#(
    parameter int OUT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  src_e             start_src,
    input  logic [REG_W-1:0] start_word,
    input  logic             hclk_fall,
    input  logic             frame_n,
    output logic             active,
    output src_e             cur_src,
    output logic             msb,
    output logic             done
);
    typedef struct packed {
        logic             active;
        src_e             src;
        logic [REG_W-1:0] sh;
        logic [CNT_W-1:0] left;
    } shst_t;

    localparam logic [CNT_W-1:0] OUT_LEN = CNT_W'(OUT_W);
    localparam logic [CNT_W-1:0] REG_LEN = CNT_W'(REG_W);

    shst_t st_d, st_q;
    logic  step;

    always_comb begin
        st_d = st_q;
        done = 1'b0;
        step = st_q.active && hclk_fall && !frame_n;
        if (!st_q.active && start) begin
            st_d.active = 1'b1;
            st_d.src    = start_src;
            st_d.sh     = start_word;
            st_d.left   = (start_src == SRC_OUT) ? OUT_LEN : REG_LEN;
        end else if (step) begin
            st_d.sh   = {st_q.sh[REG_W-2:0], 1'b0};
            st_d.left = st_q.left - 1'b1;
            if (st_q.left == CNT_W'(1)) begin
                st_d.active = 1'b0;
                done        = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{active: 1'b0, src: SRC_OUT, sh: '0, left: '0};
        else        st_q <= st_d;
    end

    assign active  = st_q.active;
    assign cur_src = st_q.src;
    assign msb     = st_q.sh[REG_W-1];

    // R9
    pause_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.active && frame_n) |=> $stable(st_q.left) && $stable(st_q.sh));
    // R2
    len_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.active |-> (st_q.left != '0) && (st_q.left <= REG_LEN));
endmodule

// File: rtl/hcrp_top.sv
module hcrp_top
    import hcrp_pkg::*;
#(
    parameter int OUT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hclk,
    input  logic             frame_n,
    input  logic             addr_sel,
    input  logic             cal_sel,
    input  logic             load_new,
    input  logic [OUT_W-1:0] new_word,
    input  logic [REG_W-1:0] ctrl_word,
    input  logic [REG_W-1:0] cal_word,
    output logic             rdy_n,
    output logic             sdo,
    output logic             sdo_oe
);
    logic             hclk_rise, hclk_fall, frm_rise, frm_fall;
    logic             active, msb, done, start, out_done, block_load;
    src_e             req_src, cur_src;
    logic [REG_W-1:0] start_word;
    logic [OUT_W-1:0] out_word;

    hcrp_edge #(.IDLE(1'b0)) u_hclk_edge (
        .clk(clk), .rst_n(rst_n), .lvl(hclk), .rise(hclk_rise), .fall(hclk_fall));
    hcrp_edge #(.IDLE(1'b1)) u_frame_edge (
        .clk(clk), .rst_n(rst_n), .lvl(frame_n), .rise(frm_rise), .fall(frm_fall));

    always_comb begin
        if (!addr_sel)    req_src = SRC_CTRL;
        else if (cal_sel) req_src = SRC_CAL;
        else              req_src = SRC_OUT;
        unique case (req_src)
            SRC_CTRL: start_word = ctrl_word;
            SRC_CAL:  start_word = cal_word;
            default:  start_word = REG_W'(out_word) << (REG_W - OUT_W);
        endcase
        start      = frm_fall && !active && (req_src != SRC_OUT || !rdy_n);
        out_done   = done && (cur_src == SRC_OUT);
        block_load = (active && cur_src == SRC_OUT) || (start && req_src == SRC_OUT);
    end

    hcrp_shifter #(.OUT_W(OUT_W)) u_shifter (
        .clk(clk), .rst_n(rst_n), .start(start), .start_src(req_src),
        .start_word(start_word), .hclk_fall(hclk_fall), .frame_n(frame_n),
        .active(active), .cur_src(cur_src), .msb(msb), .done(done));

    hcrp_outreg #(.OUT_W(OUT_W)) u_outreg (
        .clk(clk), .rst_n(rst_n), .load_new(load_new), .new_word(new_word),
        .block_load(block_load), .out_done(out_done),
        .out_word(out_word), .rdy_n(rdy_n));

    assign sdo_oe = active && !frame_n;
    assign sdo    = sdo_oe ? msb : 1'b0;

    // R4
    no_out_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_fall && !active && addr_sel && !cal_sel && rdy_n) |=> !active);
    // R2
    rdy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rdy_n) |-> $past(done && cur_src == SRC_OUT));
    // R6
    ctrl_keeps_rdy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && cur_src != SRC_OUT && !load_new) |=> $stable(rdy_n));
endmodule

// File: tb/hcrp_top_bench.sv
module hcrp_top_bench;
    localparam int CLK_P = 10;
    localparam int OUT_W = 16;

    logic clk = 0, rst_n = 0, hclk = 0, frame_n = 1, addr_sel = 0, cal_sel = 0;
    logic load_new = 0;
    logic [OUT_W-1:0] new_word = '0;
    logic [23:0] ctrl_word = '0, cal_word = '0;
    logic rdy_n, sdo, sdo_oe;

    int checks = 0, errors = 0;
    logic [OUT_W-1:0] m_out = '0;
    logic m_rdy_n = 1'b1;

    hcrp_top #(.OUT_W(OUT_W)) u_hcrp_top (.*);

    always #(CLK_P/2) clk = ~clk;

    task automatic chk(input logic ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic do_load(input logic [OUT_W-1:0] w);
        new_word = w; load_new = 1; tick(); load_new = 0;
        m_out = w; m_rdy_n = 0;
        chk(rdy_n === 1'b0, "R1 rdy_n after load", rdy_n, 0);
    endtask

    task automatic hpulse(input logic do_ld, input logic [OUT_W-1:0] w);
        hclk = 1; tick();
        hclk = 0;
        if (do_ld) begin new_word = w; load_new = 1; end
        tick(); load_new = 0;
    endtask

    // src 0 out, 1 ctrl, 2 cal; pause_at<0 = none; drop_at<0 = none
    task automatic read_word(input int src, input logic [23:0] exp, input int len,
                             input int pause_at, input int drop_at);
        logic rdy_before;
        rdy_before = rdy_n;
        addr_sel = (src != 1); cal_sel = (src == 2);
        frame_n = 0; tick();
        for (int i = 0; i < len; i++) begin
            chk(sdo_oe === 1'b1 && sdo === exp[len-1-i], "R8 bit", sdo, exp[len-1-i]);
            if (i == pause_at) begin
                frame_n = 1; tick();
                chk(sdo_oe === 1'b0, "R9 pause oe", sdo_oe, 0);
                hpulse(1'b0, '0);
                frame_n = 0; tick();
                chk(sdo_oe === 1'b1 && sdo === exp[len-1-i], "R9 resume bit", sdo, exp[len-1-i]);
            end
            if (i == len - 2)
                chk(rdy_n === rdy_before, "R2 rdy before last edge", rdy_n, rdy_before);
            hpulse(i == drop_at, OUT_W'($urandom));
        end
        chk(sdo_oe === 1'b0, "R2 oe off at end", sdo_oe, 0);
        if (src == 0) begin
            m_rdy_n = 1;
            chk(rdy_n === 1'b1, "R2 R3 rdy_n high after out read", rdy_n, 1);
        end else
            chk(rdy_n === m_rdy_n, "R6 R7 rdy_n unchanged", rdy_n, m_rdy_n);
        frame_n = 1; tick();
    endtask

    task automatic refused_read();
        addr_sel = 1; cal_sel = 0;
        frame_n = 0; tick(); tick();
        chk(sdo_oe === 1'b0, "R4 no transfer when rdy_n high", sdo_oe, 0);
        hpulse(1'b0, '0);
        chk(sdo_oe === 1'b0 && rdy_n === 1'b1, "R4 still idle", sdo_oe, 0);
        frame_n = 1; tick();
    endtask

    initial begin
        #(CLK_P * 200000);
        checks++; errors++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        repeat (3) tick();
        chk(rdy_n === 1'b1 && sdo_oe === 1'b0, "R10 reset state", {rdy_n, sdo_oe}, 2);
        rst_n = 1; tick();
        chk(rdy_n === 1'b1 && sdo_oe === 1'b0, "R10 after reset release", {rdy_n, sdo_oe}, 2);

        // directed corners
        refused_read();                                   // R4
        ctrl_word = 24'hA5C3_7E; read_word(1, ctrl_word, 24, -1, -1); // R6 with rdy_n high
        do_load(16'h1234); do_load(16'hBEEF);             // R5 latest wins
        read_word(0, {8'h0, 16'hBEEF}, OUT_W, 5, -1);     // R5 R9
        do_load(16'h0F0F);
        read_word(0, {8'h0, 16'h0F0F}, OUT_W, -1, 3);     // R3 drop mid-read
        refused_read();                                   // R3 dropped word not ready
        do_load(16'hC001);
        cal_word = 24'h81_0042; read_word(2, cal_word, 24, 0, -1); // R7 rdy_n low kept
        ctrl_word = 24'h3C_F001; read_word(1, ctrl_word, 24, 23, -1); // R6
        read_word(0, {8'h0, 16'hC001}, OUT_W, OUT_W - 1, -1);

        // constrained random mix
        for (int k = 0; k < 60; k++) begin
            int op;
            int pa;
            op = $urandom_range(0, 3);
            pa = ($urandom_range(0, 1) == 1) ? $urandom_range(0, OUT_W - 1) : -1;
            ctrl_word = 24'($urandom); cal_word = 24'($urandom);
            case (op)
                0: do_load(OUT_W'($urandom));
                1: if (m_rdy_n) refused_read();
                   else read_word(0, 24'(m_out), OUT_W, pa,
                                  ($urandom_range(0, 2) == 0) ? $urandom_range(0, OUT_W - 1) : -1);
                2: read_word(1, ctrl_word, 24, pa, -1);
                default: read_word(2, cal_word, 24, pa, -1);
            endcase
            chk(rdy_n === m_rdy_n, "R1 R2 rdy_n model", rdy_n, m_rdy_n);
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule